// File: doc/BRIEF.md
# Signed Restoring Sequential Divider

This block divides one two's-complement integer by another, one quotient bit per clock. A request is a single-cycle `start` with the dividend and divisor on their inputs. The divisor goes into a divisor register. The dividend goes into a shift pair made of a partial-remainder register and a quotient register, and the partial-remainder register holds the dividend's sign extension. Each iteration shifts that pair left by one place. The divisor is then subtracted when the partial remainder and the divisor have the same sign, and added when their signs differ. The trial result is kept, and a 1 enters the low quotient bit, when the partial remainder keeps its sign or reaches zero. Otherwise the partial remainder reverts to its shifted value and a 0 enters.

After `WIDTH` iterations, one further cycle takes the two's complement of the magnitude quotient when the operands had opposite signs. The block then pulses `done`. The quotient is truncated toward zero, and the remainder takes the dividend's sign. A zero divisor skips the iterations entirely: it finishes in one cycle and raises a flag.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `signed_restoring_div`

## Requirements
- R1: Once the synchronized reset has released, `busy`, `done` and `div_zero` are all low until the first request is accepted.
- R2: A `start` seen while `busy` is high is ignored: the division already running finishes with its own operands, and its busy time is unchanged.
- R3: A request with a nonzero divisor holds `busy` high for exactly `WIDTH`+1 consecutive cycles, beginning in the cycle after `start` is sampled.
- R4: `done` is high for one cycle, in the cycle after the last busy cycle, and `busy` is low whenever `done` is high.
- R5: For a nonzero divisor, `quotient` equals the true quotient truncated toward zero, taken modulo 2^`WIDTH`. The quotient is negative when the operands have opposite signs.
- R6: For a nonzero divisor, `remainder` is zero or has the dividend's sign, its magnitude is below the divisor's, and dividend = quotient × divisor + remainder.
- R7: The most negative dividend divided by −1 gives a quotient that wraps to the most negative value, with a remainder of zero.
- R8: A zero divisor raises `done` in the cycle after `start` with `busy` staying low. It also sets `div_zero` high, makes `quotient` all ones and makes `remainder` equal to the dividend.
- R9: `div_zero` stays high until the next accepted request, and that request clears it when its divisor is nonzero.
- R10: `quotient`, `remainder` and `div_zero` hold their values from the `done` cycle until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| start | input | 1 | Request strobe, sampled only while idle |
| dividend | input | WIDTH | Signed dividend, sampled with `start` |
| divisor | input | WIDTH | Signed divisor, sampled with `start` |
| busy | output | 1 | High while iterations or the sign fix-up are running |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Signed quotient, valid from `done` on |
| remainder | output | WIDTH | Signed remainder, valid from `done` on |
| div_zero | output | 1 | Set when the accepted request had a zero divisor |

## Verification
The embedded properties assume two things about the inputs. The operands matter only in the cycle that `start` is sampled while idle. `WIDTH` is at least two, so the quotient register has bits below its top bit. Under those assumptions the partial remainder never takes the sign opposite to the dividend, never needs more than `WIDTH` bits, and ends smaller in magnitude than the divisor. The stimulus changes `start` and the operands only on falling clock edges and holds `start` for one cycle. At a width of five it sweeps every dividend and divisor pair, which includes all the zero-divisor cases and the most-negative-by-minus-one case. One extra request raises `start` with different operands part way through a running division.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;

endpackage

// File: rtl/sdiv_rst_sync.sv
module sdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter  int WIDTH = 8,
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          zero_div,
  output logic          load,
  output logic          load_zero,
  output logic          step_en,
  output logic          fin_en,
  output logic [CW-1:0] iter,
  output logic          busy,
  output logic          done,
  output logic          div_zero
);

  localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

  sdiv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          dz_q, dz_d;
  logic          accept;

  always_comb begin
    accept    = (state_q == ST_IDLE) && start;
    load      = accept && !zero_div;
    load_zero = accept && zero_div;
    step_en   = (state_q == ST_RUN);
    fin_en    = (state_q == ST_FIN);

    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST_ITER) begin
          state_d = ST_FIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    done_d = fin_en || load_zero;
    dz_d   = accept ? zero_div : dz_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      dz_q    <= dz_d;
    end
  end

  assign iter     = cnt_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign div_zero = dz_q;

  // Checker-only run length counter for the busy window
  logic [CW:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q <= '0;
    end else begin
      run_len_q <= busy ? (run_len_q + 1'b1) : '0;
    end
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |-> (run_len_q == (CW+1)'(WIDTH)))
    else $error("busy window length differs from WIDTH+1");

  p_fin_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> (done && !busy))
    else $error("done did not follow the final busy cycle");

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter  int WIDTH = 8,
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic [WIDTH-1:0] m_in,
  input  logic [CW-1:0]    iter,
  output logic [WIDTH:0]   a_out,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH:0] a_sh;
  logic [WIDTH:0] m_ext;
  logic [WIDTH:0] trial;
  logic           same_sign;
  logic           rest_nz;
  logic           keep;

  always_comb begin
    a_sh      = {a_in, q_in[WIDTH-1]};
    m_ext     = {m_in[WIDTH-1], m_in};
    same_sign = (a_sh[WIDTH] == m_ext[WIDTH]);
    trial     = same_sign ? (a_sh - m_ext) : (a_sh + m_ext);
  end

  // Dividend bits not yet shifted into the partial remainder
  always_comb begin
    rest_nz = 1'b0;
    for (int b = 1; b < WIDTH; b++) begin
      if ((b > int'(iter)) && q_in[b-1]) begin
        rest_nz = 1'b1;
      end
    end
  end

  always_comb begin
    if (trial == '0) begin
      keep = !a_sh[WIDTH] || !rest_nz;
    end else begin
      keep = (trial[WIDTH] == a_sh[WIDTH]);
    end
    a_out = keep ? trial : a_sh;
    q_out = {q_in[WIDTH-2:0], keep};
  end

endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath #(
  parameter  int WIDTH = 8,
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_zero,
  input  logic             step_en,
  input  logic             fin_en,
  input  logic [CW-1:0]    iter,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  logic [WIDTH-1:0] a_q, a_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic [WIDTH-1:0] m_q, m_d;
  logic             dsign_q, dsign_d;
  logic             neg_q, neg_d;
  logic [WIDTH:0]   a_step;
  logic [WIDTH-1:0] q_step;

  sdiv_step #(.WIDTH(WIDTH)) u_step (
    .a_in  (a_q),
    .q_in  (q_q),
    .m_in  (m_q),
    .iter  (iter),
    .a_out (a_step),
    .q_out (q_step)
  );

  always_comb begin
    a_d     = a_q;
    q_d     = q_q;
    m_d     = m_q;
    dsign_d = dsign_q;
    neg_d   = neg_q;
    if (load || load_zero) begin
      m_d     = divisor;
      dsign_d = dividend[WIDTH-1];
      neg_d   = dividend[WIDTH-1] ^ divisor[WIDTH-1];
      if (load) begin
        a_d = {WIDTH{dividend[WIDTH-1]}};
        q_d = dividend;
      end else begin
        a_d = dividend;
        q_d = '1;
      end
    end else if (step_en) begin
      a_d = a_step[WIDTH-1:0];
      q_d = q_step;
    end else if (fin_en) begin
      if (neg_q) begin
        q_d = -q_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      q_q     <= '0;
      m_q     <= '0;
      dsign_q <= 1'b0;
      neg_q   <= 1'b0;
    end else begin
      a_q     <= a_d;
      q_q     <= q_d;
      m_q     <= m_d;
      dsign_q <= dsign_d;
      neg_q   <= neg_d;
    end
  end

  assign quotient  = q_q;
  assign remainder = a_q;

  function automatic logic [WIDTH:0] mag(input logic [WIDTH-1:0] v);
    logic [WIDTH:0] ext;
    ext = {v[WIDTH-1], v};
    return ext[WIDTH] ? (~ext + 1'b1) : ext;
  endfunction

  p_m_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en || fin_en) |=> $stable(m_q))
    else $error("divisor register changed during a running division");

  p_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (a_step[WIDTH] == a_step[WIDTH-1]))
    else $error("partial remainder outgrew WIDTH bits");

  p_prem_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ((a_q == '0) || (a_q[WIDTH-1] == dsign_q)))
    else $error("partial remainder took the sign opposite the dividend");

  p_rem_mag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_en |-> (mag(a_q) < mag(m_q)))
    else $error("final remainder not smaller than divisor");

endmodule

// File: rtl/signed_restoring_div.sv
module signed_restoring_div #(
  parameter  int WIDTH = 8,
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_zero
);

  logic          rst_n_s;
  logic          load;
  logic          load_zero;
  logic          step_en;
  logic          fin_en;
  logic [CW-1:0] iter;
  logic          zero_div;

  assign zero_div = (divisor == '0);

  sdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .zero_div  (zero_div),
    .load      (load),
    .load_zero (load_zero),
    .step_en   (step_en),
    .fin_en    (fin_en),
    .iter      (iter),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero)
  );

  sdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (load),
    .load_zero (load_zero),
    .step_en   (step_en),
    .fin_en    (fin_en),
    .iter      (iter),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy)
    else $error("done raised while busy");

  p_zero_done_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && start && (divisor == '0)) |=> (done && div_zero && !busy))
    else $error("zero divisor did not complete at once");

endmodule

// File: tb/signed_restoring_div_test.sv
module signed_restoring_div_test;

  localparam int W          = 5;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         div_zero;

  int compared;
  int mismatched;

  signed_restoring_div #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issues a request and waits for done; returns the busy cycle count
  task automatic issue(input int a, input int b, output int nbusy);
    int waited;
    @(negedge clk);
    start    = 1'b1;
    dividend = a[W-1:0];
    divisor  = b[W-1:0];
    @(negedge clk);
    start  = 1'b0;
    nbusy  = 0;
    waited = 0;
    while (!done && waited < 4*W + 10) begin
      if (busy) nbusy++;
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_one(input int a, input int b);
    int           nbusy;
    int           eq;
    int           er;
    logic [W-1:0] eqv;
    logic [W-1:0] erv;
    string        qtag;
    issue(a, b, nbusy);
    check(done == 1'b1, "R4 done seen", int'(done), 1);
    check(busy == 1'b0, "R4 busy low with done", int'(busy), 0);
    if (b == 0) begin
      check(nbusy == 0, "R8 no busy", nbusy, 0);
      check(div_zero == 1'b1, "R8 flag", int'(div_zero), 1);
      check(quotient == '1, "R8 quotient", int'($signed(quotient)), -1);
      check(remainder == a[W-1:0], "R8 remainder", int'($signed(remainder)), a);
    end else begin
      eq   = a / b;
      er   = a % b;
      eqv  = eq[W-1:0];
      erv  = er[W-1:0];
      qtag = ((a == -(1 << (W-1))) && (b == -1)) ? "R7 wrap quotient" : "R5 quotient";
      check(nbusy == W + 1, "R3 busy length", nbusy, W + 1);
      check(div_zero == 1'b0, "R9 flag clear", int'(div_zero), 0);
      check(quotient == eqv, qtag, int'($signed(quotient)), int'($signed(eqv)));
      check(remainder == erv, "R6 remainder", int'($signed(remainder)), er);
    end
    @(negedge clk);
    check(done == 1'b0, "R4 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int nbusy;
    int waited;
    compared   = 0;
    mismatched = 0;
    rst_n      = 1'b0;
    start      = 1'b0;
    dividend   = '0;
    divisor    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs after reset release
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(div_zero == 1'b0, "R1 div_zero", int'(div_zero), 0);

    // R2: second start during a running division is ignored
    @(negedge clk);
    start    = 1'b1;
    dividend = W'(13);
    divisor  = W'(3);
    @(negedge clk);
    start  = 1'b0;
    nbusy  = 0;
    waited = 0;
    while (!done && waited < 4*W + 10) begin
      if (busy) nbusy++;
      if (waited == 2) begin
        start    = 1'b1;
        dividend = W'(-7);
        divisor  = W'(2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    check(nbusy == W + 1, "R2 busy length kept", nbusy, W + 1);
    check(quotient == W'(4), "R2 quotient kept", int'($signed(quotient)), 4);
    check(remainder == W'(1), "R2 remainder kept", int'($signed(remainder)), 1);

    // R10: results held after done
    repeat (3) @(negedge clk);
    check(quotient == W'(4), "R10 quotient held", int'($signed(quotient)), 4);
    check(remainder == W'(1), "R10 remainder held", int'($signed(remainder)), 1);
    check(busy == 1'b0, "R10 idle", int'(busy), 0);

    // R9: zero flag held, then cleared by a nonzero request
    run_one(9, 0);
    repeat (2) @(negedge clk);
    check(div_zero == 1'b1, "R9 flag held", int'(div_zero), 1);
    check(remainder == W'(9), "R10 zero-case remainder held", int'($signed(remainder)), 9);
    run_one(-9, 4);

    // Exhaustive sweep over all operand pairs
    for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
      for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
        run_one(a, b);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule